// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into data words. The frame format is selected at run time by control inputs: the data width (one to eight bits), an optional parity bit with even or odd sense, one or two stop bits, and one of two schemes for marking address frames. In the first scheme each frame carries an extra address bit. In the second, a long idle period on the line marks the next frame as an address frame. The receiver is clocked by the system clock and advances on a tick that runs at sixteen times the baud rate.

Every completed frame produces a one-clock valid strobe. Alongside it the block presents the data word (right-aligned, with the unused upper bits at zero), an address-frame flag, a parity-error flag and a framing-error flag. All outputs hold their values until the next frame completes. Reception runs only while the asynchronous-enable input is 1.

Top module: `serial_frame_rx`

## Requirements
- R1: The size code n on `cfg_size` receives n+1 data bits. Code 0 gives 1 bit and code 7 gives 8 bits. Bits are assembled LSB first into `rx_data` bit 0 upward, and every bit of `rx_data` at position n+1 or above reads 0.
- R2: With `cfg_par_en` = 1, one parity bit follows the data bits and the address bit. `rx_perr` is 1 when the count of ones over data, address bit and parity bit is odd while `cfg_par_odd` = 0, or even while `cfg_par_odd` = 1. With `cfg_par_en` = 0, no parity bit is expected and `rx_perr` is 0.
- R3: With `cfg_two_stop` = 1, two stop bits are expected; with 0, one is expected. A low level at any expected stop sample sets `rx_ferr` for that frame, and `rx_valid` still pulses.
- R4: With `cfg_addr_mode` = 1, one address bit follows the data, and its value is reported on `rx_addr`.
- R5: With `cfg_addr_mode` = 0, `rx_addr` is 1 for a frame whose start edge followed at least 10 bit periods (160 ticks) of high line since the previous frame, the previous false start, or reset. Otherwise it is 0.
- R6: A falling edge starts a frame only if the line is still low at the sample 8 ticks later. A shorter low pulse produces no frame.
- R7: While `cfg_async` = 0, no frame is received and `rx_valid` stays 0.
- R8: `rx_valid` is high for exactly one clock per frame. The four result outputs change only in that clock.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-clock pulse at 16x the baud rate |
| cfg_size | input | 3 | Data size code, bits = code + 1 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_two_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| cfg_addr_mode | input | 1 | 1 = address-bit scheme, 0 = idle-line scheme |
| cfg_async | input | 1 | Must be 1 for reception |
| rx_data | output | 8 | Received data word, zero-extended |
| rx_valid | output | 1 | One-clock strobe per completed frame |
| rx_addr | output | 1 | Address-frame flag |
| rx_perr | output | 1 | Parity-error flag |
| rx_ferr | output | 1 | Framing-error flag |

## Verification
A wrong bit index or a wrong state sequence makes the receiver sample the wrong field. This shows up within one frame as shifted data, a spurious parity error, or a framing error, because the stop sample lands on data. A stuck idle counter or a missing false-start return shows as a wrong `rx_addr` on the next frame, or as a missing strobe. The stimulus varies width, parity sense, stop count and address scheme frame by frame. Each result is therefore compared within one frame time of the fault.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int DW        = 8,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxd,
  input  logic                  tick16,
  input  logic [$clog2(DW)-1:0] cfg_size,
  input  logic                  cfg_par_en,
  input  logic                  cfg_par_odd,
  input  logic                  cfg_two_stop,
  input  logic                  cfg_addr_mode,
  input  logic                  cfg_async,
  output logic [DW-1:0]         rx_data,
  output logic                  rx_valid,
  output logic                  rx_addr,
  output logic                  rx_perr,
  output logic                  rx_ferr
);
  localparam int SW       = $clog2(DW);
  localparam int CW       = $clog2(OVS);
  localparam int IDLE_MAX = IDLE_BITS * OVS;
  localparam int IW       = $clog2(IDLE_MAX + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ADDR, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [2:0]    sync;
  logic          lvl_q;
  logic [CW-1:0] cnt;
  logic [SW-1:0] idx;
  logic [DW-1:0] shreg;
  logic          acc, abit, perr_q, ferr_q, idle_hit;
  logic [IW-1:0] idle_cnt;

  wire rx_s     = sync[1];
  wire fall     = lvl_q & ~rx_s;
  wire at_mid   = (cnt == MID);
  wire at_last  = (cnt == LAST);
  wire idle_top = (idle_cnt == IW'(IDLE_MAX));
  st_t after_data;
  st_t after_addr;

  assign after_addr = cfg_par_en ? S_PAR : S_STOP1;
  assign after_data = cfg_addr_mode ? S_ADDR : after_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lvl_q    <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      acc      <= 1'b0;
      abit     <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      idle_hit <= 1'b0;
      idle_cnt <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_addr  <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick16) lvl_q <= rx_s;
      if (!cfg_async) begin
        st <= S_IDLE;
      end else if (tick16) begin
        case (st)
          S_IDLE: begin
            if (fall) begin
              st       <= S_START;
              cnt      <= '0;
              idle_hit <= idle_top;
              idle_cnt <= '0;
            end else if (!rx_s) begin
              idle_cnt <= '0;
            end else if (!idle_top) begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          S_START: begin
            if (at_mid) begin
              cnt <= '0;
              if (!rx_s) begin
                st     <= S_DATA;
                idx    <= '0;
                shreg  <= '0;
                acc    <= 1'b0;
                abit   <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (!at_last) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              case (st)
                S_DATA: begin
                  shreg[idx] <= rx_s;
                  acc        <= acc ^ rx_s;
                  if (idx == cfg_size) st <= after_data;
                  else                 idx <= idx + 1'b1;
                end
                S_ADDR: begin
                  abit <= rx_s;
                  acc  <= acc ^ rx_s;
                  st   <= after_addr;
                end
                S_PAR: begin
                  perr_q <= acc ^ rx_s ^ cfg_par_odd;
                  st     <= S_STOP1;
                end
                S_STOP1: begin
                  if (cfg_two_stop) begin
                    ferr_q <= ~rx_s;
                    st     <= S_STOP2;
                  end else begin
                    st       <= S_IDLE;
                    idle_cnt <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= shreg;
                    rx_addr  <= cfg_addr_mode ? abit : idle_hit;
                    rx_perr  <= cfg_par_en & perr_q;
                    rx_ferr  <= ~rx_s;
                  end
                end
                S_STOP2: begin
                  st       <= S_IDLE;
                  idle_cnt <= '0;
                  rx_valid <= 1'b1;
                  rx_data  <= shreg;
                  rx_addr  <= cfg_addr_mode ? abit : idle_hit;
                  rx_perr  <= cfg_par_en & perr_q;
                  rx_ferr  <= ferr_q | ~rx_s;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [$clog2(DW)-1:0] cfg_size,
  input logic                  cfg_par_en,
  input logic                  cfg_async,
  input logic [DW-1:0]         rx_data,
  input logic                  rx_valid,
  input logic                  rx_addr,
  input logic                  rx_perr,
  input logic                  rx_ferr
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({rx_data, rx_addr, rx_perr, rx_ferr}));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> cfg_size) >> 1) == '0);

  // R2
  perr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_par_en) |-> !rx_perr);

  // R7
  async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_async |=> !rx_valid);
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_par_en(cfg_par_en),
  .cfg_async(cfg_async), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_addr(rx_addr), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
);

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  localparam int BITCLK = 32;
  localparam int NV = 8;
  // {size, par_en, par_odd, two_stop, addr_mode, addr_bit, data, flip_parity, bad_stop}
  localparam logic [17:0] VECS [NV] = '{
    {3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1B, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0},
    {3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b1},
    {3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h06, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0, rxd = 1, tick16 = 0;
  logic [2:0] cfg_size = 0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_addr_mode = 0, cfg_async = 1;
  logic [7:0] rx_data;
  logic rx_valid, rx_addr, rx_perr, rx_ferr;
  int errors = 0, checks = 0, nvalid = 0;
  logic [7:0] g_data;
  logic g_addr, g_perr, g_ferr;
  bit done = 0;
  logic tdiv = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    tdiv   <= ~tdiv;
    tick16 <= tdiv;
  end

  serial_frame_rx u_dut (.*);

  always @(negedge clk) if (rx_valid) begin
    nvalid++;
    g_data = rx_data; g_addr = rx_addr; g_perr = rx_perr; g_ferr = rx_ferr;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(logic v, int n = BITCLK);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [2:0] sz, logic pen, logic podd, logic two, logic am,
                      logic ab, logic [7:0] d, logic flip, logic bad);
    logic p;
    cfg_size = sz; cfg_par_en = pen; cfg_par_odd = podd;
    cfg_two_stop = two; cfg_addr_mode = am;
    p = podd ^ (am & ab);
    hold_bit(0);
    for (int i = 0; i <= int'(sz); i++) begin
      hold_bit(d[i]);
      p ^= d[i];
    end
    if (am) hold_bit(ab);
    if (pen) hold_bit(p ^ flip);
    if (two) hold_bit(1);
    hold_bit(~bad);
    hold_bit(1, 2 * BITCLK);
  endtask

  task automatic expect_frame(string req, logic [7:0] d, logic a, logic pe, logic fe);
    chk({req, " valid"}, nvalid, 1);
    chk({req, " data"}, g_data, d);
    chk({req, " addr"}, g_addr, a);
    chk({req, " perr"}, g_perr, pe);
    chk({req, " ferr"}, g_ferr, fe);
    nvalid = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9", {rx_data, rx_valid, rx_addr, rx_perr, rx_ferr}, 0);
    rst_n = 1;
    // R5 long idle after reset flags address frame, short gap does not
    hold_bit(1, 11 * BITCLK);
    send(3'd7, 0, 0, 0, 0, 0, 8'h3C, 0, 0);
    expect_frame("R5 long idle", 8'h3C, 1, 0, 0);
    send(3'd7, 0, 0, 0, 0, 0, 8'hC3, 0, 0);
    expect_frame("R5 short gap", 8'hC3, 0, 0, 0);

    for (int k = 0; k < NV; k++) begin
      logic [17:0] v;
      logic [7:0] m;
      v = VECS[k];
      m = 8'hFF >> (3'd7 - v[17:15]);
      send(v[17:15], v[14], v[13], v[12], v[11], v[10], v[9:2], v[1], v[0]);
      // R1 width/LSB first, R2 parity, R3 stop, R4 address bit
      expect_frame($sformatf("R1/R2/R3/R4 vec%0d", k), v[9:2] & m,
                   v[11] & v[10], v[14] & v[1], v[0]);
    end

    // R6 short low pulse is not a start
    cfg_addr_mode = 0;
    hold_bit(0, 6);
    hold_bit(1, 20 * BITCLK);
    chk("R6 glitch", nvalid, 0);
    chk("R6 data kept", rx_data, 8'h06);
    send(3'd7, 0, 0, 0, 0, 0, 8'h5A, 0, 0);
    expect_frame("R6/R5 recovery", 8'h5A, 1, 0, 0);

    // R7 async disabled
    cfg_async = 0;
    send(3'd7, 0, 0, 0, 0, 0, 8'h77, 0, 0);
    chk("R7 no frame", nvalid, 0);
    chk("R7 data kept", rx_data, 8'h5A);
    cfg_async = 1;
    hold_bit(1, 2 * BITCLK);
    send(3'd1, 1, 1, 0, 1, 0, 8'h02, 0, 0);
    expect_frame("R7 resumed", 8'h02, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule